// File: doc/BRIEF.md
# Host Counter Estimator with Link Calibration

This block keeps a free-running local timebase and turns it into an estimate of a host's counter. The estimate can then be written into outgoing data packets. The work happens in two phases.

In the calibration phase the host sends a stream of 64-bit writes. Each write carries the host's counter value at the moment it was sent. The block times the spacing between consecutive accepted writes in local clock cycles and averages a fixed number of those gaps. That average serves as the link-delay offset.

When calibration is left, the local counter takes the last host value received and from then on advances by one each cycle. The block ignores any further host writes. On every cycle it adds the offset to the local count and multiplies the sum by a programmable host-to-local frequency ratio. A packet builder samples the result just before each packet leaves.

Top module: `rce_top`

## Requirements
- R1: While reset is held, `est_valid` is 0 and `est_value` is 0.
- R2: In calibration, each accepted write after the first closes one gap. A gap is the number of clock edges since the previous accepted write. The offset is the sum of the first 2^K gaps shifted right by K bits (K=2 by default, so 4 gaps). A write in the same cycle that `cal_en` rises counts as the first write.
- R3: On the edge where `cal_en` goes from 1 to 0 with all 2^K gaps measured, the local counter loads the last accepted host value. On every other edge it increments by one.
- R4: `est_value` equals ((local count + offset) × `ratio`) >> 16, truncated to 64 bits. `ratio` is unsigned 16.16 fixed point. The value is registered from the local count, offset and `ratio` of the previous cycle, so a `ratio` change shows up one cycle later.
- R5: `est_valid` rises one cycle after a completed calibration exit. If calibration is left before 2^K gaps have been measured, `est_valid` stays 0.
- R6: When `cal_en` is 0, `wr_valid` and `wr_data` have no effect on the estimate.
- R7: Writes that arrive in calibration after the 2^K-th gap leave the offset unchanged but still update the host value that is loaded.
- R8: A rise of `cal_en` discards earlier calibration results. `est_valid` falls two edges after the edge where `cal_en` was first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timebase clock, derived from the shared link reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | 1 selects calibration, 0 selects run |
| wr_valid | input | 1 | A host counter write is present this cycle |
| wr_data | input | 64 | Host counter value carried by the write |
| ratio | input | 32 | Host/local frequency ratio, unsigned 16.16 |
| est_valid | output | 1 | Estimate is usable |
| est_value | output | 64 | Estimated host counter |

## Verification
A wrong gap sum or wrong shift does not show up during calibration. It appears as a constant error in `est_value` on the first valid cycle after calibration is left, and the error scales with `ratio`. A wrong load value or a wrong increment rule shows up in that same first estimate, or in the slope of later estimates. A missed restart or a missed gap count shows at `est_valid` within two cycles of the phase change. Each stimulus is therefore followed by a read of the estimate at a known cycle offset from the load edge.

// File: rtl/rce_pkg.sv
package rce_pkg;
  localparam int CNT_W   = 64;
  localparam int RATIO_W = 32;
  localparam int FRAC_W  = 16;
  localparam int PROD_W  = CNT_W + RATIO_W;

  // Scaled host estimate: (count + offset) * ratio, fixed point, truncated.
  function automatic logic [CNT_W-1:0] scale_est(
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   ofs,
    input logic [RATIO_W-1:0] ratio
  );
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(cnt + ofs) * PROD_W'(ratio);
    return prod[FRAC_W +: CNT_W];
  endfunction
endpackage

// File: rtl/rce_gap_meter.sv
module rce_gap_meter #(
  parameter int K     = 2,
  parameter int GAP_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cal_start,
  input  logic                      accept,
  input  logic [rce_pkg::CNT_W-1:0] wr_data,
  output logic [GAP_W-1:0]          delta,
  output logic                      done,
  output logic [rce_pkg::CNT_W-1:0] last_host
);
  localparam int N     = 1 << K;
  localparam int SUM_W = GAP_W + K;

  logic [GAP_W-1:0] timer;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] sum_next;
  logic [K:0]       n_gaps;
  logic             have_first;
  logic             take_gap;

  assign sum_next = sum + SUM_W'(timer);
  assign take_gap = accept && have_first && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer      <= '0;
      sum        <= '0;
      n_gaps     <= '0;
      have_first <= 1'b0;
      done       <= 1'b0;
      delta      <= '0;
    end else if (cal_start) begin
      sum        <= '0;
      n_gaps     <= '0;
      done       <= 1'b0;
      have_first <= accept;
      timer      <= GAP_W'(1);
    end else if (accept) begin
      have_first <= 1'b1;
      timer      <= GAP_W'(1);
      if (take_gap) begin
        sum    <= sum_next;
        n_gaps <= n_gaps + 1'b1;
        if (n_gaps == (K+1)'(N-1)) begin
          done  <= 1'b1;
          delta <= GAP_W'(sum_next >> K);
        end
      end
    end else if (timer != '1) begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_host <= '0;
    else if (accept) last_host <= wr_data;
  end
endmodule

// File: rtl/rce_timebase.sv
module rce_timebase (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [rce_pkg::CNT_W-1:0] load_val,
  output logic [rce_pkg::CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rce_scaler.sv
module rce_scaler (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid_in,
  input  logic [rce_pkg::CNT_W-1:0]   cnt,
  input  logic [rce_pkg::CNT_W-1:0]   ofs,
  input  logic [rce_pkg::RATIO_W-1:0] ratio,
  output logic                        est_valid,
  output logic [rce_pkg::CNT_W-1:0]   est_value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_valid <= 1'b0;
      est_value <= '0;
    end else begin
      est_valid <= valid_in;
      est_value <= rce_pkg::scale_est(cnt, ofs, ratio);
    end
  end
endmodule

// File: rtl/rce_top.sv
module rce_top #(
  parameter int K     = 2,
  parameter int GAP_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cal_en,
  input  logic        wr_valid,
  input  logic [63:0] wr_data,
  input  logic [31:0] ratio,
  output logic        est_valid,
  output logic [63:0] est_value
);
  import rce_pkg::*;

  logic             cal_q;
  logic             cal_start;
  logic             cal_end;
  logic             accept;
  logic             load_evt;
  logic             calibrated;
  logic             gaps_done;
  logic [GAP_W-1:0] delta;
  logic [CNT_W-1:0] ofs;
  logic [CNT_W-1:0] last_host;
  logic [CNT_W-1:0] local_cnt;

  assign cal_start = cal_en & ~cal_q;
  assign cal_end   = ~cal_en & cal_q;
  assign accept    = wr_valid & cal_en;
  assign load_evt  = cal_end & gaps_done;
  assign ofs       = CNT_W'(delta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q      <= 1'b0;
      calibrated <= 1'b0;
    end else begin
      cal_q <= cal_en;
      if (cal_start)     calibrated <= 1'b0;
      else if (load_evt) calibrated <= 1'b1;
    end
  end

  rce_gap_meter #(.K(K), .GAP_W(GAP_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_start (cal_start),
    .accept    (accept),
    .wr_data   (wr_data),
    .delta     (delta),
    .done      (gaps_done),
    .last_host (last_host)
  );

  rce_timebase u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .load_val (last_host),
    .cnt      (local_cnt)
  );

  rce_scaler u_scale (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (calibrated),
    .cnt       (local_cnt),
    .ofs       (ofs),
    .ratio     (ratio),
    .est_valid (est_valid),
    .est_value (est_value)
  );
endmodule

// File: rtl/rce_chk.sv
module rce_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cal_en,
  input logic        wr_valid,
  input logic        accept,
  input logic        cal_start,
  input logic        load_evt,
  input logic        gaps_done,
  input logic        est_valid,
  input logic [63:0] ofs,
  input logic [63:0] last_host,
  input logic [63:0] local_cnt
);
  // R3: load takes the captured host value
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> local_cnt == $past(last_host));

  // R3: otherwise the timebase advances by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> local_cnt == $past(local_cnt) + 64'd1);

  // R5: valid only follows a completed calibration exit
  a_r5_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(est_valid) |-> $past(load_evt, 2));

  // R6: run-mode writes leave the captured host value alone
  a_r6_run_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !cal_en) |=> $stable(last_host));

  // R7: late calibration writes do not disturb the offset
  a_r7_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && gaps_done && !cal_start) |=> $stable(ofs));

  // R8: restarting calibration drops validity
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> ##2 !est_valid);
endmodule

bind rce_top rce_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cal_en    (cal_en),
  .wr_valid  (wr_valid),
  .accept    (accept),
  .cal_start (cal_start),
  .load_evt  (load_evt),
  .gaps_done (gaps_done),
  .est_valid (est_valid),
  .ofs       (ofs),
  .last_host (last_host),
  .local_cnt (local_cnt)
);

// File: tb/sim_rce_top.sv
`timescale 1ns/1ps
module sim_rce_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cal_en;
  logic        wr_valid;
  logic [63:0] wr_data;
  logic [31:0] ratio;
  logic        est_valid;
  logic [63:0] est_value;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  rce_top u0 (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .ratio(ratio), .est_valid(est_valid), .est_value(est_value)
  );

  // {gap0, gap1, gap2, gap3 (8b each), last host value (64b), ratio (32b)}
  localparam logic [127:0] TBL [4] = '{
    {8'd10, 8'd10, 8'd10, 8'd10, 64'h0000_0000_0000_1000, 32'h0001_0000},
    {8'd3,  8'd7,  8'd12, 8'd5,  64'h0000_00AB_CDEF_0000, 32'h0002_0000},
    {8'd1,  8'd1,  8'd1,  8'd2,  64'h8000_0000_0000_0010, 32'h0002_0000},
    {8'd20, 8'd4,  8'd9,  8'd30, 64'h0000_0000_0000_1234, 32'h0000_8000}
  };

  // Reference: widen to 128 bits, multiply, keep bits 16..79.
  function automatic logic [63:0] ref_est(input logic [63:0] c, input logic [63:0] d,
                                          input logic [31:0] r);
    logic [127:0] w;
    w = {64'd0, c + d} * {96'd0, r};
    return w[79:16];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] d, input int gap);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cal_en = 1'b0; wr_valid = 1'b0; wr_data = '0; ratio = 32'h0001_0000;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(est_valid), 64'd0);
    chk("R1 value in reset", est_value, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table: calibrate with four gaps, leave, read the estimate (R2 R3 R4 R5)
    for (int i = 0; i < 4; i++) begin
      logic [63:0] h;
      logic [63:0] d;
      h = TBL[i][95:32];
      ratio = TBL[i][31:0];
      d = 64'((32'(TBL[i][127:120]) + 32'(TBL[i][119:112]) +
               32'(TBL[i][111:104]) + 32'(TBL[i][103:96])) / 4);
      cal_en = 1'b1;
      @(negedge clk);
      wr(h - 64'd4, int'(TBL[i][127:120]));
      wr(h - 64'd3, int'(TBL[i][119:112]));
      wr(h - 64'd2, int'(TBL[i][111:104]));
      wr(h - 64'd1, int'(TBL[i][103:96]));
      wr(h, 1);
      cal_en = 1'b0;
      @(negedge clk);
      chk("R5 not yet valid at load", 64'(est_valid), 64'd0);
      @(negedge clk);
      chk("R2 R3 R4 first estimate", est_value, ref_est(h, d, ratio));
      repeat (4) @(negedge clk);
      chk("R3 R4 estimate four cycles on", est_value, ref_est(h + 64'd4, d, ratio));
      chk("R5 valid after calibration", 64'(est_valid), 64'd1);
    end

    // R7 and R2: the first write coincides with the cal_en rise; a late write is not a gap
    ratio  = 32'h0001_0000;
    cal_en = 1'b1;
    wr(64'd100, 8);
    wr(64'd101, 8);
    wr(64'd102, 8);
    wr(64'd103, 8);
    wr(64'd104, 200);
    wr(64'h5000, 1);
    cal_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 late write loads value, offset from four gaps", est_value, 64'h5000 + 64'd8);

    // R6: writes in run mode have no effect
    wr_valid = 1'b1; wr_data = 64'hDEAD_BEEF_0000_0000;
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    chk("R6 run-mode writes ignored", est_value, 64'h5000 + 64'd3 + 64'd8);

    // R4: ratio change takes effect one cycle later
    ratio = 32'h0003_0000;
    @(negedge clk);
    chk("R4 new ratio", est_value, ref_est(64'h5000 + 64'd4, 64'd8, 32'h0003_0000));

    // R8: restarting calibration drops validity after two edges
    cal_en = 1'b1;
    @(negedge clk);
    chk("R8 valid one edge after restart", 64'(est_valid), 64'd1);
    @(negedge clk);
    chk("R8 invalid two edges after restart", 64'(est_valid), 64'd0);

    // R5: leaving with only two gaps keeps the estimate invalid
    wr(64'd10, 5);
    wr(64'd11, 5);
    wr(64'd12, 1);
    cal_en = 1'b0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk("R5 early exit stays invalid", 64'(est_valid), 64'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule